// File: doc/BRIEF.md
# Root Port Error Aggregator

This block sits inside a root port and merges two kinds of error events: error messages received from devices below the port, and errors the port detects on its own. Each accepted event is sorted by severity (correctable, non-fatal, fatal). The merged events feed two reporting paths, each with its own enables. The native path raises an interrupt request, with a one-cycle pulse for message-interrupt generation, while an enabled error status bit is set. The firmware-first path sends a per-severity system-error pulse to a platform-level error collector.

The block holds a root control register with three system-error enables, a root error command register with three interrupt enables, and a forwarding enable. The forwarding enable decides whether received messages are accepted. The block also holds a write-1-to-clear status word and the source IDs of the first correctable and the first uncorrectable event. One configuration write port (`cfg_addr`: 0 root control, 1 root error command, 2 status clear, 3 forwarding enable) programs all of it.

The interrupt generator is a three-state machine:
- IRQ_IDLE: no enabled status bit is set.
- IRQ_FIRE: a single cycle in which the pulse is driven.
- IRQ_HOLD: the request stays high.

Transitions:
- *arm*: IRQ_IDLE to IRQ_FIRE when the enabled-status condition becomes true.
- *settle*: IRQ_FIRE to IRQ_HOLD while the condition stays true.
- *abort*: IRQ_FIRE to IRQ_IDLE when the condition is already gone.
- *release*: IRQ_HOLD to IRQ_IDLE when the condition clears.

Top module: `rp_err_aggregator`

## Requirements
- R1: After reset all enables, the status word, both logged IDs, `aer_irq_o`, `msi_pulse_o` and `syserr_o` are zero.
- R2: A received message is accepted only when `msg_valid` is high and the forwarding enable (address 3, bit 0) is 1. Severity codes are 00 correctable, 01 non-fatal and 10 fatal. Code 11, and any message received while forwarding is off, leaves the status, the IDs and `syserr_o` unchanged.
- R3: Local events on `local_err` (bit 0 correctable, bit 1 non-fatal, bit 2 fatal) are always accepted, whatever the forwarding enable is.
- R4: For each severity s, `syserr_o[s]` pulses high for exactly the one cycle after an accepted event of severity s, but only if root control bit s (address 0; bit 0 correctable, bit 1 non-fatal, bit 2 fatal) is set.
- R5: An accepted event sets status bits as follows: correctable sets bit 0 (correctable received); non-fatal or fatal sets bit 2 (uncorrectable received); fatal also sets bit 4; non-fatal also sets bit 5.
- R6: Status bit 1 (multiple correctable) and bit 3 (multiple uncorrectable) are set when an event of that class arrives while the matching received bit is already set. They are also set when two or more events of that class are accepted in the same cycle.
- R7: The source ID of an event is loaded into `cor_src_id_o` or `uncor_src_id_o` only while the matching received bit is clear. A local event uses `own_id`. When a message and a local event of one class arrive together, the message ID is kept.
- R8: A write to address 2 clears each status bit written as 1. A bit being set in the same cycle stays set.
- R9: `aer_irq_o` is high while any of these is true: bit 0 is set with command bit 0, bit 5 is set with command bit 1, or bit 4 is set with command bit 2. It rises two cycles after the status bit or enable that makes it true, and falls two cycles after the condition ends. Root control has no effect on it.
- R10: `msi_pulse_o` is high for one cycle, in the first cycle `aer_irq_o` is high. It does not pulse again until `aer_irq_o` has fallen.
- R11: `root_ctl_o`, `err_cmd_o` and `fwd_en_o` show the last value written to addresses 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A received error message is present this cycle |
| msg_sev | input | 2 | Severity code of the received message |
| msg_src_id | input | ID_W | Requester ID carried by the message |
| local_err | input | 3 | One-cycle local error events, one bit per severity |
| own_id | input | ID_W | ID of the root port itself |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target select |
| cfg_wdata | input | 6 | Configuration write data |
| root_ctl_o | output | 3 | System-error enables per severity |
| err_cmd_o | output | 3 | Interrupt enables per severity |
| fwd_en_o | output | 1 | Forwarding enable for received messages |
| err_status_o | output | 6 | Error status word |
| cor_src_id_o | output | ID_W | ID of first correctable event |
| uncor_src_id_o | output | ID_W | ID of first uncorrectable event |
| aer_irq_o | output | 1 | Native interrupt request level |
| msi_pulse_o | output | 1 | One-cycle request for message-interrupt generation |
| syserr_o | output | 3 | Per-severity system-error pulses |

## Verification
The assertions assume the following about the inputs:
- `local_err` and `msg_valid` are single-cycle events, sampled on the clock.
- At most one message arrives per cycle.
- Configuration writes do not coincide with the reset release.

The bench drives every input just after a falling edge and returns each strobe to zero after one cycle. It therefore never holds an event across two edges unless it means to send two events. It issues at most one message and one configuration write per cycle, and it combines a message with a local event or a clear only in the scenarios that test those collisions.

// File: rtl/rpea_pkg.sv
package rpea_pkg;
    localparam int SEV_N  = 3;
    localparam int STAT_W = 6;
    localparam int CFG_W  = STAT_W;

    typedef enum logic [1:0] {
        SEV_COR   = 2'b00,
        SEV_NF    = 2'b01,
        SEV_FATAL = 2'b10,
        SEV_RSVD  = 2'b11
    } sev_e;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_FIRE = 2'd1,
        IRQ_HOLD = 2'd2
    } irq_state_e;

    localparam int ST_COR       = 0;
    localparam int ST_MULTI_COR = 1;
    localparam int ST_UNC       = 2;
    localparam int ST_MULTI_UNC = 3;
    localparam int ST_FATAL     = 4;
    localparam int ST_NF        = 5;

    localparam logic [1:0] CFG_ROOT_CTL = 2'd0;
    localparam logic [1:0] CFG_ERR_CMD  = 2'd1;
    localparam logic [1:0] CFG_STAT_CLR = 2'd2;
    localparam logic [1:0] CFG_FWD      = 2'd3;
endpackage

// File: rtl/rpea_event_merge.sv
module rpea_event_merge
    import rpea_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [ID_W-1:0]  msg_src_id,
    input  logic             fwd_en,
    input  logic [SEV_N-1:0] local_err,
    input  logic [ID_W-1:0]  own_id,
    output logic [SEV_N-1:0] sev_hit,
    output logic [1:0]       cor_cnt,
    output logic [1:0]       unc_cnt,
    output logic [ID_W-1:0]  cor_id,
    output logic [ID_W-1:0]  unc_id
);
    logic [SEV_N-1:0] msg_hit;

    for (genvar s = 0; s < SEV_N; s++) begin : g_sev
        assign msg_hit[s] = msg_valid && fwd_en && (msg_sev == 2'(s));
        assign sev_hit[s] = msg_hit[s] | local_err[s];
    end

    always_comb begin
        cor_cnt = {1'b0, msg_hit[SEV_COR]} + {1'b0, local_err[SEV_COR]};
        unc_cnt = {1'b0, msg_hit[SEV_NF] | msg_hit[SEV_FATAL]}
                + {1'b0, local_err[SEV_NF]} + {1'b0, local_err[SEV_FATAL]};
        cor_id  = msg_hit[SEV_COR] ? msg_src_id : own_id;
        unc_id  = (msg_hit[SEV_NF] | msg_hit[SEV_FATAL]) ? msg_src_id : own_id;
    end
endmodule

// File: rtl/rpea_status_log.sv
module rpea_status_log
    import rpea_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEV_N-1:0]  sev_hit,
    input  logic [1:0]        cor_cnt,
    input  logic [1:0]        unc_cnt,
    input  logic [ID_W-1:0]   cor_id,
    input  logic [ID_W-1:0]   unc_id,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status,
    output logic [ID_W-1:0]   cor_src_id,
    output logic [ID_W-1:0]   unc_src_id
);
    logic [STAT_W-1:0] set_mask;
    logic [STAT_W-1:0] stat_q;
    logic [ID_W-1:0]   cor_id_q;
    logic [ID_W-1:0]   unc_id_q;

    always_comb begin
        set_mask               = '0;
        set_mask[ST_COR]       = (cor_cnt != 2'd0);
        set_mask[ST_MULTI_COR] = (cor_cnt > 2'd1) || ((cor_cnt != 2'd0) && stat_q[ST_COR]);
        set_mask[ST_UNC]       = (unc_cnt != 2'd0);
        set_mask[ST_MULTI_UNC] = (unc_cnt > 2'd1) || ((unc_cnt != 2'd0) && stat_q[ST_UNC]);
        set_mask[ST_FATAL]     = sev_hit[SEV_FATAL];
        set_mask[ST_NF]        = sev_hit[SEV_NF];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            cor_id_q <= '0;
            unc_id_q <= '0;
        end else begin
            stat_q <= set_mask | (stat_q & ~clr_mask);
            if (set_mask[ST_COR] && !stat_q[ST_COR])
                cor_id_q <= cor_id;
            if (set_mask[ST_UNC] && !stat_q[ST_UNC])
                unc_id_q <= unc_id;
        end
    end

    assign status     = stat_q;
    assign cor_src_id = cor_id_q;
    assign unc_src_id = unc_id_q;

    AST_COR_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[ST_COR] |=> $stable(cor_id_q)); // R7
    AST_UNC_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[ST_UNC] |=> $stable(unc_id_q)); // R7
    AST_MULTI_COR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_MULTI_COR]) |-> $past(cor_cnt != 2'd0)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_cnt != 2'd0) |=> stat_q[ST_UNC]); // R8
endmodule

// File: rtl/rpea_syserr_gen.sv
module rpea_syserr_gen
    import rpea_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEV_N-1:0] sev_hit,
    input  logic [SEV_N-1:0] root_ctl,
    output logic [SEV_N-1:0] syserr
);
    for (genvar s = 0; s < SEV_N; s++) begin : g_sys
        logic pulse_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= sev_hit[s] & root_ctl[s];
        end
        assign syserr[s] = pulse_q;

        AST_SYSERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            syserr[s] |-> $past(root_ctl[s])); // R4
    end
endmodule

// File: rtl/rpea_irq_fsm.sv
module rpea_irq_fsm
    import rpea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_cond,
    output logic aer_irq,
    output logic msi_pulse
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (irq_cond)  state_d = IRQ_FIRE;
            IRQ_FIRE: state_d = irq_cond ? IRQ_HOLD : IRQ_IDLE;
            IRQ_HOLD: if (!irq_cond) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        aer_irq   = 1'b0;
        msi_pulse = 1'b0;
        unique case (state_q)
            IRQ_IDLE: ;
            IRQ_FIRE: begin aer_irq = 1'b1; msi_pulse = 1'b1; end
            IRQ_HOLD: aer_irq = 1'b1;
            default:  ;
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |=> !msi_pulse); // R10
    AST_ARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cond && !aer_irq) |=> msi_pulse); // R10
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_cond |=> !aer_irq); // R9
endmodule

// File: rtl/rp_err_aggregator.sv
module rp_err_aggregator
    import rpea_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [1:0]        msg_sev,
    input  logic [ID_W-1:0]   msg_src_id,
    input  logic [2:0]        local_err,
    input  logic [ID_W-1:0]   own_id,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [5:0]        cfg_wdata,
    output logic [2:0]        root_ctl_o,
    output logic [2:0]        err_cmd_o,
    output logic              fwd_en_o,
    output logic [5:0]        err_status_o,
    output logic [ID_W-1:0]   cor_src_id_o,
    output logic [ID_W-1:0]   uncor_src_id_o,
    output logic              aer_irq_o,
    output logic              msi_pulse_o,
    output logic [2:0]        syserr_o
);
    logic [SEV_N-1:0]  root_ctl_q, err_cmd_q;
    logic              fwd_en_q;
    logic [STAT_W-1:0] clr_mask;
    logic [SEV_N-1:0]  sev_hit;
    logic [1:0]        cor_cnt, unc_cnt;
    logic [ID_W-1:0]   cor_id, unc_id;
    logic [STAT_W-1:0] status;
    logic              irq_cond;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_ctl_q <= '0;
            err_cmd_q  <= '0;
            fwd_en_q   <= 1'b0;
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                CFG_ROOT_CTL: root_ctl_q <= cfg_wdata[SEV_N-1:0];
                CFG_ERR_CMD:  err_cmd_q  <= cfg_wdata[SEV_N-1:0];
                CFG_STAT_CLR: ;
                CFG_FWD:      fwd_en_q   <= cfg_wdata[0];
                default:      ;
            endcase
        end
    end

    assign clr_mask = (cfg_wr && cfg_addr == CFG_STAT_CLR) ? cfg_wdata[STAT_W-1:0] : '0;

    rpea_event_merge #(.ID_W(ID_W)) u_merge (
        .msg_valid (msg_valid),
        .msg_sev   (msg_sev),
        .msg_src_id(msg_src_id),
        .fwd_en    (fwd_en_q),
        .local_err (local_err),
        .own_id    (own_id),
        .sev_hit   (sev_hit),
        .cor_cnt   (cor_cnt),
        .unc_cnt   (unc_cnt),
        .cor_id    (cor_id),
        .unc_id    (unc_id)
    );

    rpea_status_log #(.ID_W(ID_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .sev_hit   (sev_hit),
        .cor_cnt   (cor_cnt),
        .unc_cnt   (unc_cnt),
        .cor_id    (cor_id),
        .unc_id    (unc_id),
        .clr_mask  (clr_mask),
        .status    (status),
        .cor_src_id(cor_src_id_o),
        .unc_src_id(uncor_src_id_o)
    );

    rpea_syserr_gen u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .sev_hit (sev_hit),
        .root_ctl(root_ctl_q),
        .syserr  (syserr_o)
    );

    assign irq_cond = (status[ST_COR]   & err_cmd_q[SEV_COR])
                    | (status[ST_NF]    & err_cmd_q[SEV_NF])
                    | (status[ST_FATAL] & err_cmd_q[SEV_FATAL]);

    rpea_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_cond (irq_cond),
        .aer_irq  (aer_irq_o),
        .msi_pulse(msi_pulse_o)
    );

    assign root_ctl_o   = root_ctl_q;
    assign err_cmd_o    = err_cmd_q;
    assign fwd_en_o     = fwd_en_q;
    assign err_status_o = status;

    AST_FWD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en_q && local_err == '0 && !cfg_wr) |=> $stable(err_status_o)); // R2
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_sev == SEV_RSVD && local_err == '0 && !cfg_wr) |=> ($stable(err_status_o) && syserr_o == '0)); // R2
    AST_LOCAL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        local_err[SEV_FATAL] |=> (err_status_o[ST_FATAL] && err_status_o[ST_UNC])); // R3
endmodule

// File: tb/rp_err_aggregator_bench.sv
module rp_err_aggregator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 16;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            msg_valid;
    logic [1:0]      msg_sev;
    logic [ID_W-1:0] msg_src_id;
    logic [2:0]      local_err;
    logic [ID_W-1:0] own_id;
    logic            cfg_wr;
    logic [1:0]      cfg_addr;
    logic [5:0]      cfg_wdata;
    logic [2:0]      root_ctl_o, err_cmd_o, syserr_o;
    logic            fwd_en_o, aer_irq_o, msi_pulse_o;
    logic [5:0]      err_status_o;
    logic [ID_W-1:0] cor_src_id_o, uncor_src_id_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_err_aggregator #(.ID_W(ID_W)) u_rp_err_aggregator (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src_id(msg_src_id), .local_err(local_err), .own_id(own_id),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .root_ctl_o(root_ctl_o), .err_cmd_o(err_cmd_o), .fwd_en_o(fwd_en_o),
        .err_status_o(err_status_o), .cor_src_id_o(cor_src_id_o),
        .uncor_src_id_o(uncor_src_id_o), .aer_irq_o(aer_irq_o),
        .msi_pulse_o(msi_pulse_o), .syserr_o(syserr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [5:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic send_msg(input logic [1:0] sev, input logic [ID_W-1:0] id);
        msg_valid = 1'b1; msg_sev = sev; msg_src_id = id;
        tick();
        msg_valid = 1'b0;
    endtask

    task automatic send_local(input logic [2:0] e);
        local_err = e;
        tick();
        local_err = '0;
    endtask

    task automatic test_reset();
        check("R1 status", 32'(err_status_o), 0);
        check("R1 irq", 32'({aer_irq_o, msi_pulse_o}), 0);
        check("R1 syserr", 32'(syserr_o), 0);
        check("R1 enables", 32'({root_ctl_o, err_cmd_o, fwd_en_o}), 0);
        check("R1 ids", 32'({cor_src_id_o, uncor_src_id_o}), 0);
    endtask

    task automatic test_local_syserr();
        cfg_write(2'd0, 6'b000101);
        check("R11 root_ctl", 32'(root_ctl_o), 32'h5);
        send_local(3'b001);
        check("R4 syserr cor", 32'(syserr_o), 32'h1);
        check("R5 cor status", 32'(err_status_o), 32'h01);
        check("R7 own id", 32'(cor_src_id_o), 32'h00AA);
        tick();
        check("R4 one cycle", 32'(syserr_o), 0);
        send_local(3'b010);
        check("R4 nf disabled", 32'(syserr_o), 0);
        check("R5 nf status", 32'(err_status_o), 32'h25);
        check("R9 irq off without cmd", 32'(aer_irq_o), 0);
        cfg_write(2'd2, 6'h3f);
        check("R8 clear all", 32'(err_status_o), 0);
    endtask

    task automatic test_fwd_gate();
        send_msg(2'b10, 16'h1234);
        check("R2 fwd off status", 32'(err_status_o), 0);
        check("R2 fwd off syserr", 32'(syserr_o), 0);
        send_local(3'b100);
        check("R3 local fatal status", 32'(err_status_o), 32'h14);
        check("R3 local fatal syserr", 32'(syserr_o), 32'h4);
        cfg_write(2'd2, 6'h3f);
        cfg_write(2'd3, 6'h01);
        check("R11 fwd", 32'(fwd_en_o), 1);
    endtask

    task automatic test_multi_id();
        send_msg(2'b00, 16'hA001);
        check("R5 msg cor", 32'(err_status_o), 32'h01);
        check("R7 first cor id", 32'(cor_src_id_o), 32'hA001);
        send_msg(2'b00, 16'hB002);
        check("R6 multi cor", 32'(err_status_o), 32'h03);
        check("R7 id held", 32'(cor_src_id_o), 32'hA001);
        msg_valid = 1'b1; msg_sev = 2'b01; msg_src_id = 16'hC003; local_err = 3'b100;
        tick();
        msg_valid = 1'b0; local_err = '0;
        check("R6 same-cycle multi unc", 32'(err_status_o), 32'h3F);
        check("R7 msg id wins", 32'(uncor_src_id_o), 32'hC003);
        check("R4 fatal syserr", 32'(syserr_o), 32'h4);
        cfg_write(2'd2, 6'h3f);
        send_msg(2'b11, 16'hD004);
        check("R2 reserved code", 32'(err_status_o), 0);
        check("R2 reserved syserr", 32'(syserr_o), 0);
    endtask

    task automatic test_set_wins();
        cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 6'h01;
        msg_valid = 1'b1; msg_sev = 2'b00; msg_src_id = 16'hE005;
        tick();
        cfg_wr = 1'b0; msg_valid = 1'b0;
        check("R8 set wins", 32'(err_status_o[0]), 1);
        check("R7 reload after clear", 32'(cor_src_id_o), 32'hE005);
        cfg_write(2'd2, 6'h3f);
        tick(); tick();
    endtask

    task automatic test_irq();
        send_msg(2'b00, 16'h0F0F);
        tick(); tick();
        check("R9 no cmd no irq", 32'(aer_irq_o), 0);
        cfg_write(2'd1, 6'b000001);
        check("R11 err_cmd", 32'(err_cmd_o), 1);
        check("R9 not yet", 32'(aer_irq_o), 0);
        tick();
        check("R10 pulse", 32'({aer_irq_o, msi_pulse_o}), 32'h3);
        tick();
        check("R10 pulse single", 32'({aer_irq_o, msi_pulse_o}), 32'h2);
        send_msg(2'b00, 16'h0F10);
        tick();
        check("R10 no repeat", 32'({aer_irq_o, msi_pulse_o}), 32'h2);
        cfg_write(2'd2, 6'h03);
        check("R9 still high", 32'(aer_irq_o), 1);
        tick();
        check("R9 released", 32'(aer_irq_o), 0);
        cfg_write(2'd1, 6'b000100);
        send_local(3'b001);
        tick();
        check("R9 cor masked", 32'(aer_irq_o), 0);
        cfg_write(2'd0, 6'b000000);
        send_local(3'b100);
        check("R9 fatal pending", 32'(aer_irq_o), 0);
        tick();
        check("R10 fatal pulse", 32'({aer_irq_o, msi_pulse_o}), 32'h3);
        check("R9 root ctl irrelevant", 32'(syserr_o), 0);
        cfg_write(2'd2, 6'h3f);
        tick();
        check("R9 fatal released", 32'(aer_irq_o), 0);
    endtask

    initial begin
        rst_n = 1'b0; msg_valid = 1'b0; msg_sev = '0; msg_src_id = '0;
        local_err = '0; own_id = 16'h00AA; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_local_syserr();
        test_fwd_gate();
        test_multi_id();
        test_set_wins();
        test_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule